// File: doc/BRIEF.md
# Cluster Shape Code Encoder

This block turns one finished pixel cluster into a single 32-bit word for the readout stream. A cluster arrives as an anchor coordinate (x, y) and a 3x3 occupancy bitmap taken relative to that anchor. The block replaces the bitmap with a 10-bit shape code and packs that code with the coordinates. There is one more input, an overflow marker. A cluster that does not fit the window, or a shape that cannot be encoded, gets a reserved code and a flag bit.

Two paths produce the shape code. The first is a single-cycle fast coder. It covers a short list of the most frequent shapes, and it also covers every shape that is symmetric under both mirror axes, since such a shape encodes its own bitmap directly. Any other shape falls through to a search of a constant shape table. The table is sorted by the number of fired pixels, and each popcount group starts with its most frequent shape. The search jumps to the group that matches the cluster's popcount and tests one entry per clock. Common shapes therefore come back soonest.

The controller is a three-state machine. IDLE accepts a cluster. On a fast hit, an empty group or an overflow, IDLE goes to HOLD; otherwise it goes to SEARCH. SEARCH stays in SEARCH while it walks the group. It goes to HOLD when an entry matches or when the group is used up. HOLD presents the word and returns to IDLE once the consumer takes it. Only one cluster is in flight at a time, so words leave in the order the clusters were accepted.

Top module: `cluster_shape_encoder`

## Requirements
- R1: The output word holds the shape code in bits [31:22], x in [21:11], y in [10:1] and the unencodable flag in bit [0].
- R2: The bitmap bit for window row r and column c is r*3+c, with the anchor at bit 0. The fast list maps 9'h001, 9'h003, 9'h009, 9'h011, 9'h00B, 9'h01B, 9'h007 and 9'h1FF to codes 0 through 7 in that order. Its result is valid in the cycle after acceptance, and the fast list wins over every other rule.
- R3: A bitmap that is equal to both its left-right mirror and its top-bottom mirror, and is not in the fast list, gets the code 10'h200 plus the bitmap value, with the flag clear. The word is valid in the cycle after acceptance.
- R4: Any other bitmap is looked up among the table entries that have the same popcount. If it is the p-th entry of that group (counting from 1), it gets that entry's code, with the flag clear, 1+p cycles after acceptance.
- R5: A bitmap missing from its group gets the code 10'h3FF with the flag set, 1+n cycles after acceptance, where n is the size of the group (n may be 0).
- R6: A cluster accepted with its overflow marker high gets the code 10'h3FF with the flag set in the cycle after acceptance, whatever its bitmap.
- R7: in_ready is high only while the block is idle. A cluster offered while another is being encoded or held is not taken.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold steady. After the output handshake, out_valid is low and in_ready is high in the next cycle.
- R9: During and directly after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A cluster is offered |
| in_ready | output | 1 | The block takes a cluster this cycle |
| in_bitmap | input | 9 | 3x3 occupancy, bit r*3+c |
| in_x | input | 11 | Anchor column |
| in_y | input | 10 | Anchor row |
| in_ovf | input | 1 | Cluster exceeded the window |
| out_valid | output | 1 | Encoded word is present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed code, coordinates and flag |

## Verification
A wrong state value shows up as a latency error. If SEARCH starts at the wrong group boundary or moves by the wrong step, out_valid rises in a cycle other than 1+p, and the bench's per-cycle comparison catches that on the first clock where the two disagree. A wrong captured bitmap or coordinate appears in the word itself in the cycle it becomes valid. A HOLD state that leaks, in either direction, shows up as a changed word during a stall or as in_ready high while a cluster is still pending.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int CSE_WIN    = 3;
    localparam int CSE_CODE_W = 10;
    localparam int CSE_X_W    = 11;
    localparam int CSE_Y_W    = 10;
    localparam int CSE_FAST_N = 8;
    localparam int CSE_TBL_N  = 11;

    localparam logic [CSE_CODE_W-1:0] CSE_CODE_MISS = 10'h3FF;
    localparam logic [CSE_CODE_W-1:0] CSE_SYM_BASE  = 10'h200;

    // Frequent shapes, index equals the emitted code
    localparam logic [8:0] CSE_FAST_SHAPES [CSE_FAST_N] = '{
        9'h001, 9'h003, 9'h009, 9'h011, 9'h00B, 9'h01B, 9'h007, 9'h1FF
    };

    // Fallback table, ascending popcount, most frequent first in a group
    localparam logic [8:0] CSE_TBL_SHAPES [CSE_TBL_N] = '{
        9'h002, 9'h008, 9'h004,
        9'h006, 9'h012, 9'h030,
        9'h013, 9'h01A, 9'h049,
        9'h036,
        9'h03F
    };

    localparam logic [CSE_CODE_W-1:0] CSE_TBL_CODES [CSE_TBL_N] = '{
        10'h010, 10'h011, 10'h012,
        10'h020, 10'h021, 10'h022,
        10'h030, 10'h031, 10'h032,
        10'h040,
        10'h060
    };

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HOLD   = 2'd2
    } cse_state_e;

endpackage

// File: rtl/cse_fast_coder.sv
module cse_fast_coder #(
    parameter int WIN    = 3,
    parameter int CW     = 10,
    parameter int FAST_N = 8,
    localparam int NBITS = WIN * WIN,
    parameter logic [NBITS-1:0] FAST_SHAPES [FAST_N] = cse_pkg::CSE_FAST_SHAPES,
    parameter logic [CW-1:0] SYM_BASE = cse_pkg::CSE_SYM_BASE
) (
    input  logic [NBITS-1:0] bitmap,
    output logic             hit,
    output logic [CW-1:0]    code
);

    logic [NBITS-1:0]  lr_flip;
    logic [NBITS-1:0]  tb_flip;
    logic [FAST_N-1:0] list_eq;
    logic              symmetric;

    for (genvar r = 0; r < WIN; r++) begin : g_row
        for (genvar c = 0; c < WIN; c++) begin : g_col
            assign lr_flip[r*WIN+c] = bitmap[r*WIN+(WIN-1-c)];
            assign tb_flip[r*WIN+c] = bitmap[(WIN-1-r)*WIN+c];
        end
    end

    for (genvar i = 0; i < FAST_N; i++) begin : g_list
        assign list_eq[i] = (bitmap == FAST_SHAPES[i]);
    end

    assign symmetric = (lr_flip == bitmap) && (tb_flip == bitmap);

    always_comb begin
        hit  = 1'b0;
        code = '0;
        if (symmetric) begin
            hit  = 1'b1;
            code = SYM_BASE | CW'(bitmap);
        end
        // scanned downwards so the lowest list index wins over everything
        for (int i = FAST_N - 1; i >= 0; i--) begin
            if (list_eq[i]) begin
                hit  = 1'b1;
                code = CW'(i);
            end
        end
    end

endmodule

// File: rtl/cse_shape_table.sv
module cse_shape_table #(
    parameter int NBITS = 9,
    parameter int CW    = 10,
    parameter int DEPTH = 11,
    parameter logic [NBITS-1:0] SHAPES [DEPTH] = cse_pkg::CSE_TBL_SHAPES,
    parameter logic [CW-1:0]    CODES  [DEPTH] = cse_pkg::CSE_TBL_CODES,
    localparam int IW  = $clog2(DEPTH + 1),
    localparam int PCW = $clog2(NBITS + 2)
) (
    input  logic [IW-1:0]    rd_idx,
    input  logic [PCW-1:0]   pop,
    output logic [NBITS-1:0] rd_shape,
    output logic [CW-1:0]    rd_code,
    output logic [IW-1:0]    grp_lo,
    output logic [IW-1:0]    grp_hi
);

    function automatic int entries_below(int k);
        int n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if ($countones(SHAPES[i]) < k) n++;
        end
        return n;
    endfunction

    logic [IW-1:0] grp_start [NBITS+2];

    for (genvar g = 0; g < NBITS + 2; g++) begin : g_start
        localparam int START_G = entries_below(g);
        assign grp_start[g] = IW'(START_G);
    end

    assign grp_lo = grp_start[pop];
    assign grp_hi = grp_start[pop + PCW'(1)];

    always_comb begin
        rd_shape = '0;
        rd_code  = '0;
        if (int'(rd_idx) < DEPTH) begin
            rd_shape = SHAPES[rd_idx];
            rd_code  = CODES[rd_idx];
        end
    end

    // Groups only work when the table is laid out by ascending popcount
    initial begin
        for (int i = 1; i < DEPTH; i++) begin
            assert_table_sorted_R4: assert ($countones(SHAPES[i-1]) <= $countones(SHAPES[i]))
                else $error("shape table not ordered by popcount at entry %0d", i);
        end
    end

endmodule

// File: rtl/cluster_shape_encoder.sv
module cluster_shape_encoder
    import cse_pkg::*;
#(
    parameter int WIN    = CSE_WIN,
    parameter int X_W    = CSE_X_W,
    parameter int Y_W    = CSE_Y_W,
    parameter int CODE_W = CSE_CODE_W,
    parameter int FAST_N = CSE_FAST_N,
    parameter int TBL_N  = CSE_TBL_N,
    localparam int NBITS  = WIN * WIN,
    localparam int WORD_W = CODE_W + X_W + Y_W + 1,
    localparam int IW     = $clog2(TBL_N + 1),
    localparam int PCW    = $clog2(NBITS + 2),
    parameter logic [NBITS-1:0]  FAST_SHAPES [FAST_N] = CSE_FAST_SHAPES,
    parameter logic [NBITS-1:0]  TBL_SHAPES  [TBL_N]  = CSE_TBL_SHAPES,
    parameter logic [CODE_W-1:0] TBL_CODES   [TBL_N]  = CSE_TBL_CODES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NBITS-1:0]  in_bitmap,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    input  logic              in_ovf,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    localparam logic [CODE_W-1:0] MISS_CODE = '1;

    cse_state_e state_q, state_d;

    logic [NBITS-1:0]  bm_q;
    logic [X_W-1:0]    x_q;
    logic [Y_W-1:0]    y_q;
    logic [IW-1:0]     idx_q;
    logic [IW-1:0]     hi_q;
    logic [WORD_W-1:0] word_q;

    logic              accept;
    logic [PCW-1:0]    pop_in;
    logic              fast_hit;
    logic [CODE_W-1:0] fast_code;
    logic [NBITS-1:0]  tbl_shape;
    logic [CODE_W-1:0] tbl_code;
    logic [IW-1:0]     grp_lo;
    logic [IW-1:0]     grp_hi;
    logic              tbl_match;
    logic              tbl_last;
    logic              direct_done;

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_HOLD);
    assign out_data  = word_q;
    assign accept    = in_valid && in_ready;
    assign pop_in    = PCW'($countones(in_bitmap));

    cse_fast_coder #(
        .WIN        (WIN),
        .CW         (CODE_W),
        .FAST_N     (FAST_N),
        .FAST_SHAPES(FAST_SHAPES),
        .SYM_BASE   (CSE_SYM_BASE)
    ) u_fast (
        .bitmap(in_bitmap),
        .hit   (fast_hit),
        .code  (fast_code)
    );

    cse_shape_table #(
        .NBITS (NBITS),
        .CW    (CODE_W),
        .DEPTH (TBL_N),
        .SHAPES(TBL_SHAPES),
        .CODES (TBL_CODES)
    ) u_table (
        .rd_idx  (idx_q),
        .pop     (pop_in),
        .rd_shape(tbl_shape),
        .rd_code (tbl_code),
        .grp_lo  (grp_lo),
        .grp_hi  (grp_hi)
    );

    assign tbl_match   = (tbl_shape == bm_q);
    assign tbl_last    = ((idx_q + IW'(1)) == hi_q);
    assign direct_done = in_ovf || fast_hit || (grp_lo == grp_hi);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = direct_done ? ST_HOLD : ST_SEARCH;
            ST_SEARCH: if (tbl_match || tbl_last) state_d = ST_HOLD;
            ST_HOLD:   if (out_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Captured cluster, search pointer and packed word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bm_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            idx_q  <= '0;
            hi_q   <= '0;
            word_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        bm_q  <= in_bitmap;
                        x_q   <= in_x;
                        y_q   <= in_y;
                        idx_q <= grp_lo;
                        hi_q  <= grp_hi;
                        if (in_ovf || (!fast_hit && grp_lo == grp_hi))
                            word_q <= {MISS_CODE, in_x, in_y, 1'b1};
                        else if (fast_hit)
                            word_q <= {fast_code, in_x, in_y, 1'b0};
                    end
                end
                ST_SEARCH: begin
                    if (tbl_match)     word_q <= {tbl_code, x_q, y_q, 1'b0};
                    else if (tbl_last) word_q <= {MISS_CODE, x_q, y_q, 1'b1};
                    else               idx_q  <= idx_q + IW'(1);
                end
                default: ;
            endcase
        end
    end

    // Guards
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_miss_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[0]) |-> (out_data[WORD_W-1 -: CODE_W] == MISS_CODE));

    assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_ovf) |=> (out_valid && out_data[0]));

    assert_fast_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_ovf && fast_hit) |=> (out_valid && !out_data[0]));

    assert_search_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (idx_q < hi_q));

endmodule

// File: tb/cluster_shape_encoder_tb.sv
`timescale 1ns/100ps
module cluster_shape_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_bitmap = '0;
    logic [10:0] in_x = '0;
    logic [9:0]  in_y = '0;
    logic        in_ovf = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    cluster_shape_encoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_bitmap(in_bitmap), .in_x(in_x), .in_y(in_y), .in_ovf(in_ovf),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Reference data, written from the requirements
    logic [8:0] m_fast [8]  = '{9'h001, 9'h003, 9'h009, 9'h011, 9'h00B, 9'h01B, 9'h007, 9'h1FF};
    logic [8:0] m_tbl  [11] = '{9'h002, 9'h008, 9'h004, 9'h006, 9'h012, 9'h030,
                                9'h013, 9'h01A, 9'h049, 9'h036, 9'h03F};
    logic [9:0] m_code [11] = '{10'h010, 10'h011, 10'h012, 10'h020, 10'h021, 10'h022,
                                10'h030, 10'h031, 10'h032, 10'h040, 10'h060};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic bit mirror_sym(input logic [8:0] b);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                if (b[r*3+c] != b[r*3+2-c] || b[r*3+c] != b[(2-r)*3+c]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model(input logic [8:0] bm, input bit ovf,
                         output logic [9:0] code, output bit flag, output int lat);
        int pos = 0;
        if (ovf) begin code = 10'h3FF; flag = 1; lat = 1; return; end
        for (int i = 0; i < 8; i++)
            if (bm == m_fast[i]) begin code = 10'(i); flag = 0; lat = 1; return; end
        if (mirror_sym(bm)) begin code = 10'h200 + 10'(bm); flag = 0; lat = 1; return; end
        for (int i = 0; i < 11; i++) begin
            if ($countones(m_tbl[i]) == $countones(bm)) begin
                pos++;
                if (m_tbl[i] == bm) begin code = m_code[i]; flag = 0; lat = 1 + pos; return; end
            end
        end
        code = 10'h3FF; flag = 1; lat = 1 + pos;
    endtask

    // Offer one cluster, follow it cycle by cycle, optionally stall the output
    task automatic run(input logic [8:0] bm, input logic [10:0] x, input logic [9:0] y,
                       input bit ovf, input int stall, input string req);
        logic [9:0]  ecode;
        bit          eflag;
        int          lat;
        logic [31:0] exp_word;
        logic [31:0] held;
        model(bm, ovf, ecode, eflag, lat);
        exp_word = {ecode, x, y, eflag};
        @(negedge clk);
        in_bitmap = bm; in_x = x; in_y = y; in_ovf = ovf; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            check(out_valid == (k == lat), req, $sformatf("out_valid at cycle %0d", k),
                  32'(out_valid), 32'(k == lat));
            check(!in_ready, "R7", "in_ready while busy", 32'(in_ready), 32'h0);
            if (k == lat)
                check(out_data == exp_word, {req, " R1"}, "packed word", out_data, exp_word);
            else
                @(negedge clk);
        end
        held = out_data;
        for (int s = 0; s < stall; s++) begin
            in_valid = 1'b1; in_bitmap = ~bm; in_ovf = 1'b0;
            @(negedge clk);
            check(out_valid && out_data == held, "R8", "word held during stall", out_data, held);
            check(!in_ready, "R7", "offer while held", 32'(in_ready), 32'h0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R8", "idle after handshake",
              {30'h0, out_valid, in_ready}, 32'h1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R9", "in reset", {30'h0, out_valid, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R9", "after reset", {30'h0, out_valid, in_ready}, 32'h1);

        // R2 fast list
        for (int i = 0; i < 8; i++) run(m_fast[i], 11'(100 + i), 10'(50 + i), 1'b0, 0, "R2");
        // R3 double-mirror shapes
        run(9'h010, 11'd7,  10'd9,  1'b0, 0, "R3");
        run(9'h145, 11'd8,  10'd10, 1'b0, 0, "R3");
        run(9'h0BA, 11'd9,  10'd11, 1'b0, 0, "R3");
        run(9'h000, 11'd10, 10'd12, 1'b0, 0, "R3");
        // R4 every table entry, each at its own position
        for (int i = 0; i < 11; i++) run(m_tbl[i], 11'(300 + 3 * i), 10'(200 + i), 1'b0, 0, "R4");
        // R5 misses: full group, empty group
        run(9'h005, 11'd1, 10'd2, 1'b0, 0, "R5");
        run(9'h023, 11'd3, 10'd4, 1'b0, 0, "R5");
        run(9'h0F8, 11'd5, 10'd6, 1'b0, 0, "R5");
        // R6 overflow overrides fast and table shapes
        run(9'h001, 11'd12, 10'd13, 1'b1, 0, "R6");
        run(9'h03F, 11'd14, 10'd15, 1'b1, 0, "R6");
        // R1 coordinate extremes
        run(9'h003, 11'h7FF, 10'h3FF, 1'b0, 0, "R1");
        run(9'h036, 11'h000, 10'h000, 1'b0, 0, "R1");
        run(9'h012, 11'h555, 10'h2AA, 1'b0, 0, "R1");
        // R7/R8 stalled consumer with a competing offer, then ordering
        run(9'h01A, 11'd40, 10'd41, 1'b0, 4, "R8");
        run(9'h011, 11'd42, 10'd43, 1'b0, 3, "R8");
        run(9'h049, 11'd44, 10'd45, 1'b0, 0, "R7");
        repeat (2) @(negedge clk);
        summary();
    end

endmodule